// File: doc/BRIEF.md
# Round-Robin Port Service Sequencer

This block decides which of a group of power ports currently owns the shared measurement and power-ramp resources. A pointer steps through the ports in ascending order and wraps from the last port back to the first. Ports that are neither enabled nor powered are passed over, at a cost of one cycle each. When the pointer lands on a port that needs service, the block grants that port the shared resources. It then dwells on the port until the port's own logic reports the end of its bring-up (discovery, classification, power-up). For a port that is already powered, the dwell instead lasts until a run-time sample comes back from the converter. Per-port logic, the converter and the ramp engine are outside this block. They connect only through done and request handshakes.

A pending disable or a load disconnect on a powered port is handled by that port's logic only while it holds the grant, so such events take effect on the port's next turn. In normal operation the pointer runs freely. In single-step mode it stops after each port and moves one position for every write of the step bit. The block also creates two staged reset releases after supplies are good and the external reset is high. The register side is freed after a short count and the port side after a long count. Both counts are parameters.

Top module: `port_service_seq`

## Requirements
- R1: With `supplies_ok` and `rst_ext_n` both high, `reg_rst_n` goes high at the REG_REL_CYC-th rising clock edge after both inputs were seen high. It goes low at the first edge after either input drops.
- R2: `port_rst_n` goes high at the PORT_REL_CYC-th edge under the same condition and drops with `reg_rst_n`. It is never high while `reg_rst_n` is low.
- R3: The pointer `sel_idx` (port k is index k, 0-based) visits ports in ascending order and wraps from NUM_PORTS-1 to 0.
- R4: A port with both `port_en` and `port_powered` low gets no grant, and the pointer leaves it after one cycle. After port reset release the first evaluation is of index 0.
- R5: An enabled port that is not powered is granted until its `bringup_done` bit is seen high. The grant is zero on the cycle after that.
- R6: A powered port with `sample_bypass` low holds the grant with `sample_req` high until `sample_done` is seen high. Both drop on the cycle after that.
- R7: A powered port with `sample_bypass` high is granted for exactly one cycle, and `sample_req` stays low.
- R8: At most one `grant` bit is high at any time. The grant does not change while the granted port has not signalled done.
- R9: With `jog_mode` high, the pointer holds after finishing or passing a port. Each one-cycle `jog_wr` pulse then moves it exactly one position, and the port at the new position is evaluated.
- R10: A `jog_wr` pulse while a port holds the grant has no effect on the grant or on the pointer.
- R11: Clearing `jog_mode` while the pointer holds resumes free running from the next position.
- R12: While `port_rst_n` is low, `grant` is zero and `sel_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supplies_ok | input | 1 | All supplies within range |
| rst_ext_n | input | 1 | External reset, active low |
| jog_mode | input | 1 | Single-step mode select |
| jog_wr | input | 1 | One-cycle pulse: step bit written to 1 |
| sample_bypass | input | 1 | Skip run-time sampling on powered ports |
| port_en | input | NUM_PORTS | Per-port enable command |
| port_powered | input | NUM_PORTS | Per-port powered status |
| bringup_done | input | NUM_PORTS | Per-port end of bring-up or shutdown |
| sample_done | input | 1 | Shared converter finished the run-time sample |
| reg_rst_n | output | 1 | Register-side reset release, active low |
| port_rst_n | output | 1 | Port-side reset release, active low |
| grant | output | NUM_PORTS | One-hot port being serviced |
| sel_idx | output | clog2(NUM_PORTS) | Current pointer position |
| sample_req | output | 1 | Run-time sample request for the granted port |

## Verification
The bench targets the exact release edges of both reset stages. A counter off by one would release the port side a cycle early or late, or release it ahead of the registers. It counts the cycles spent passing disabled ports and the cycles to wrap back after single-step mode is left. A design that lingers on a disabled port, or that restarts from index 0 instead of the next position, misses those counts. It also drives step pulses in the middle of a dwell and checks the one-cycle grant on bypassed powered ports. A design that honours the pulse would move the grant away from an unfinished port. A design that mishandles bypass would either raise the sample request or hang waiting for a sample.

// File: rtl/psq_pkg.sv
package psq_pkg;
    typedef enum logic [1:0] {
        ST_EVAL  = 2'd0,
        ST_DWELL = 2'd1,
        ST_HOLD  = 2'd2
    } psq_state_e;
endpackage

// File: rtl/psq_por.sv
module psq_por #(
    parameter int REG_REL  = 8,
    parameter int PORT_REL = 65536
) (
    input  logic clk,
    input  logic supplies_ok,
    input  logic rst_ext_n,
    output logic reg_rel,
    output logic port_rel
);
    localparam int CW = $clog2(PORT_REL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          reg_rel;
        logic          port_rel;
    } por_t;

    por_t q, d;
    logic good;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        good = supplies_ok & rst_ext_n;
        if (!good)
            cnt_nx = '0;
        else if (q.cnt == CW'(PORT_REL))
            cnt_nx = q.cnt;
        else
            cnt_nx = q.cnt + 1'b1;
        d.cnt      = cnt_nx;
        d.reg_rel  = good && (cnt_nx >= CW'(REG_REL));
        d.port_rel = good && (cnt_nx >= CW'(PORT_REL));
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign reg_rel  = q.reg_rel;
    assign port_rel = q.port_rel;

    // R2: port side never free while register side held
    a_r2_port_after_reg: assert property (@(posedge clk) disable iff (!rst_ext_n)
        port_rel |-> reg_rel);
    // R1: loss of supplies pulls both releases low
    a_r1_supply_drop: assert property (@(posedge clk) disable iff (!rst_ext_n)
        $fell(supplies_ok) |=> (!reg_rel && !port_rel));
endmodule

// File: rtl/psq_onehot.sv
module psq_onehot #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  oh
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign oh[i] = (idx == IW'(i));
    end
endmodule

// File: rtl/psq_core.sv
module psq_core
    import psq_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int IDXW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jog_mode,
    input  logic              jog_wr,
    input  logic              sample_bypass,
    input  logic [NPORTS-1:0] port_en,
    input  logic [NPORTS-1:0] port_powered,
    input  logic [NPORTS-1:0] bringup_done,
    input  logic              sample_done,
    output logic [NPORTS-1:0] grant,
    output logic [IDXW-1:0]   sel_idx,
    output logic              sample_req
);
    typedef struct packed {
        psq_state_e        st;
        logic [IDXW-1:0]   cur;
        logic [NPORTS-1:0] gnt;
    } core_t;

    localparam core_t RST_VAL = '{st: ST_EVAL, cur: '0, gnt: '0};
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NPORTS - 1);

    core_t q, d;
    logic [NPORTS-1:0] cur_oh;
    logic [IDXW-1:0]   nxt;
    logic visit_w, pwr_w, done_w;

    psq_onehot #(.N(NPORTS), .IW(IDXW)) u_oh (
        .idx (q.cur),
        .oh  (cur_oh)
    );

    always_comb begin
        nxt     = (q.cur == LAST_IDX) ? '0 : q.cur + 1'b1;
        pwr_w   = port_powered[q.cur];
        visit_w = port_en[q.cur] | pwr_w;
        done_w  = pwr_w ? (sample_bypass | sample_done) : bringup_done[q.cur];
        d = q;
        case (q.st)
            ST_EVAL: begin
                if (visit_w) begin
                    d.gnt = cur_oh;
                    d.st  = ST_DWELL;
                end else if (jog_mode) begin
                    d.st = ST_HOLD;
                end else begin
                    d.cur = nxt;
                end
            end
            ST_DWELL: begin
                if (done_w) begin
                    d.gnt = '0;
                    if (jog_mode) begin
                        d.st = ST_HOLD;
                    end else begin
                        d.cur = nxt;
                        d.st  = ST_EVAL;
                    end
                end
            end
            ST_HOLD: begin
                if (!jog_mode || jog_wr) begin
                    d.cur = nxt;
                    d.st  = ST_EVAL;
                end
            end
            default: d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign grant      = q.gnt;
    assign sel_idx    = q.cur;
    assign sample_req = (q.st == ST_DWELL) & pwr_w & ~sample_bypass;

    // R8: one owner of the shared resources
    a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R8: grant frozen until the owner reports done
    a_r8_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DWELL && !done_w) |=> (grant == $past(grant)));
    // R5: done releases the grant on the following cycle
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DWELL && done_w) |=> (grant == '0));
    // R9: pointer stays put in step mode without a step pulse
    a_r9_jog_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD && jog_mode && !jog_wr) |=> $stable(sel_idx));
    // R6: a sample is only requested on behalf of a granted port
    a_r6_req_granted: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |-> (grant != '0));
endmodule

// File: rtl/port_service_seq.sv
module port_service_seq #(
    parameter int NUM_PORTS    = 8,
    parameter int REG_REL_CYC  = 8,
    parameter int PORT_REL_CYC = 65536,
    localparam int IDXW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 supplies_ok,
    input  logic                 rst_ext_n,
    input  logic                 jog_mode,
    input  logic                 jog_wr,
    input  logic                 sample_bypass,
    input  logic [NUM_PORTS-1:0] port_en,
    input  logic [NUM_PORTS-1:0] port_powered,
    input  logic [NUM_PORTS-1:0] bringup_done,
    input  logic                 sample_done,
    output logic                 reg_rst_n,
    output logic                 port_rst_n,
    output logic [NUM_PORTS-1:0] grant,
    output logic [IDXW-1:0]      sel_idx,
    output logic                 sample_req
);
    psq_por #(.REG_REL(REG_REL_CYC), .PORT_REL(PORT_REL_CYC)) u_por (
        .clk         (clk),
        .supplies_ok (supplies_ok),
        .rst_ext_n   (rst_ext_n),
        .reg_rel     (reg_rst_n),
        .port_rel    (port_rst_n)
    );

    psq_core #(.NPORTS(NUM_PORTS), .IDXW(IDXW)) u_core (
        .clk           (clk),
        .rst_n         (port_rst_n),
        .jog_mode      (jog_mode),
        .jog_wr        (jog_wr),
        .sample_bypass (sample_bypass),
        .port_en       (port_en),
        .port_powered  (port_powered),
        .bringup_done  (bringup_done),
        .sample_done   (sample_done),
        .grant         (grant),
        .sel_idx       (sel_idx),
        .sample_req    (sample_req)
    );
endmodule

// File: tb/port_service_seq_tb.sv
module port_service_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int REG_N = 8;
    localparam int PORT_N = 64;
    localparam int WD_CYC = 20000;
    localparam int NVEC = 6;

    // vector: [28:21] enable, [20:13] powered, [12] bypass, [11:0] four grants, first in [11:9]
    localparam logic [28:0] VECS [NVEC] = '{
        {8'b0000_0101, 8'b0000_0000, 1'b0, 3'd0, 3'd2, 3'd0, 3'd2},  // R5 two bring-ups
        {8'b1000_0000, 8'b0000_0010, 1'b0, 3'd1, 3'd7, 3'd1, 3'd7},  // R6 sampled powered port
        {8'b0000_0000, 8'b0001_0001, 1'b1, 3'd0, 3'd4, 3'd0, 3'd4},  // R7 bypass
        {8'b1100_0001, 8'b0000_0000, 1'b0, 3'd0, 3'd6, 3'd7, 3'd0},  // R3 wrap
        {8'b0001_0000, 8'b0100_0000, 1'b0, 3'd4, 3'd6, 3'd4, 3'd6},  // R4 skips
        {8'b0000_1000, 8'b0010_0000, 1'b1, 3'd3, 3'd5, 3'd3, 3'd5}   // R7 mixed
    };

    logic clk;
    logic supplies_ok, rst_ext_n, jog_mode, jog_wr, sample_bypass, sample_done;
    logic [NP-1:0] port_en, port_powered, bringup_done;
    logic reg_rst_n, port_rst_n, sample_req;
    logic [NP-1:0] grant;
    logic [2:0] sel_idx;

    int nchk = 0;
    int nfail = 0;
    bit auto_resp = 0;

    port_service_seq #(.NUM_PORTS(NP), .REG_REL_CYC(REG_N), .PORT_REL_CYC(PORT_N)) dut_i (
        .clk(clk), .supplies_ok(supplies_ok), .rst_ext_n(rst_ext_n),
        .jog_mode(jog_mode), .jog_wr(jog_wr), .sample_bypass(sample_bypass),
        .port_en(port_en), .port_powered(port_powered), .bringup_done(bringup_done),
        .sample_done(sample_done), .reg_rst_n(reg_rst_n), .port_rst_n(port_rst_n),
        .grant(grant), .sel_idx(sel_idx), .sample_req(sample_req)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int oh2idx(input logic [NP-1:0] oh);
        for (int i = 0; i < NP; i++) if (oh[i]) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ext_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_ext_n = 1'b1;
        while (!port_rst_n) @(negedge clk);
    endtask

    task automatic wait_grant(output int k);
        k = 0;
        while (grant == '0 && k < 60) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic responder();
        int gi;
        forever begin
            if (auto_resp && grant != '0) begin
                gi = oh2idx(grant);
                if (!port_powered[gi]) begin
                    bringup_done[gi] = 1'b1;
                    @(negedge clk);
                    bringup_done[gi] = 1'b0;
                end else if (!sample_bypass) begin
                    @(negedge clk);
                    sample_done = 1'b1;
                    @(negedge clk);
                    sample_done = 1'b0;
                end else begin
                    @(negedge clk);
                end
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYC, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int k;
        logic [NP-1:0] g0;
        supplies_ok = 1'b1; rst_ext_n = 1'b0; jog_mode = 1'b0; jog_wr = 1'b0;
        sample_bypass = 1'b0; sample_done = 1'b0;
        port_en = '0; port_powered = '0; bringup_done = '0;
        fork responder(); join_none
        repeat (3) @(negedge clk);
        chk(!reg_rst_n && !port_rst_n, "R1 both held in reset", reg_rst_n, 0);

        // staged release edges (R1, R2, R12)
        rst_ext_n = 1'b1;
        for (int c = 1; c <= 66; c++) begin
            @(negedge clk);
            if (c == REG_N - 1) chk(!reg_rst_n, "R1 reg early", reg_rst_n, 0);
            if (c == REG_N)     chk(reg_rst_n, "R1 reg release edge", reg_rst_n, 1);
            if (c == 20)        chk(grant == '0 && sel_idx == 0 && !port_rst_n,
                                    "R12 state during port reset", grant, 0);
            if (c == PORT_N - 1) chk(!port_rst_n, "R2 port early", port_rst_n, 0);
            if (c == PORT_N)     chk(port_rst_n, "R2 port release edge", port_rst_n, 1);
        end
        supplies_ok = 1'b0;
        @(negedge clk);
        chk(!reg_rst_n && !port_rst_n, "R1 R2 drop on supply loss",
            {reg_rst_n, port_rst_n}, 0);
        supplies_ok = 1'b1;

        // table of vectors, serviced by the responder (R3 order)
        for (int v = 0; v < NVEC; v++) begin
            int rec [4];
            int got;
            int cyc;
            logic [NP-1:0] prev;
            port_en = VECS[v][28:21];
            port_powered = VECS[v][20:13];
            sample_bypass = VECS[v][12];
            @(negedge clk);
            rst_ext_n = 1'b0;
            repeat (3) @(negedge clk);
            rst_ext_n = 1'b1;
            auto_resp = 1'b1;
            got = 0; cyc = 0; prev = '0;
            while (got < 4 && cyc < 400) begin
                @(negedge clk);
                cyc++;
                if (grant != '0 && grant != prev) begin
                    rec[got] = oh2idx(grant);
                    got++;
                end
                prev = grant;
            end
            auto_resp = 1'b0;
            for (int j = 0; j < 4; j++)
                chk(got > j && rec[j] == int'(VECS[v][11 - 3*j -: 3]),
                    $sformatf("R3 vector %0d grant %0d", v, j),
                    (got > j) ? rec[j] : -1, int'(VECS[v][11 - 3*j -: 3]));
            repeat (4) @(negedge clk);
        end

        // R4 skip cost and R5/R8 bring-up dwell
        port_en = 8'b0000_1000; port_powered = '0; sample_bypass = 1'b0;
        do_reset();
        wait_grant(k);
        chk(k == 4, "R4 cycles to reach port 3", k, 4);
        chk(grant == 8'b0000_1000 && sel_idx == 3, "R4 grant on port 3", grant, 8);
        g0 = grant;
        repeat (5) @(negedge clk);
        chk(grant == g0, "R8 grant held without done", grant, g0);
        chk(!sample_req, "R5 no sample request on bring-up", sample_req, 0);
        bringup_done[3] = 1'b1;
        @(negedge clk);
        bringup_done[3] = 1'b0;
        chk(grant == '0, "R5 grant drops after done", grant, 0);

        // R6 sampled powered port
        port_en = '0; port_powered = 8'b0010_0000; sample_bypass = 1'b0;
        do_reset();
        wait_grant(k);
        chk(grant == 8'b0010_0000 && sample_req, "R6 grant and request", grant, 32);
        repeat (3) @(negedge clk);
        chk(grant == 8'b0010_0000 && sample_req, "R6 dwell until sample", grant, 32);
        sample_done = 1'b1;
        @(negedge clk);
        sample_done = 1'b0;
        chk(grant == '0 && !sample_req, "R6 release after sample", grant, 0);

        // R7 bypass: one-cycle grant
        sample_bypass = 1'b1;
        do_reset();
        wait_grant(k);
        chk(grant == 8'b0010_0000 && !sample_req, "R7 granted without request",
            sample_req, 0);
        @(negedge clk);
        chk(grant == '0, "R7 single-cycle grant", grant, 0);

        // R9 R10 R11 single-step mode
        sample_bypass = 1'b0; port_powered = '0; port_en = 8'b0000_0110;
        jog_mode = 1'b1;
        do_reset();
        repeat (5) @(negedge clk);
        chk(sel_idx == 0 && grant == '0, "R9 holds at index 0", sel_idx, 0);
        jog_wr = 1'b1;
        @(negedge clk);
        jog_wr = 1'b0;
        chk(sel_idx == 1, "R9 one step", sel_idx, 1);
        @(negedge clk);
        chk(grant == 8'b0000_0010, "R9 stepped port granted", grant, 2);
        jog_wr = 1'b1;
        @(negedge clk);
        jog_wr = 1'b0;
        @(negedge clk);
        chk(grant == 8'b0000_0010 && sel_idx == 1, "R10 step ignored in dwell", sel_idx, 1);
        bringup_done[1] = 1'b1;
        @(negedge clk);
        bringup_done[1] = 1'b0;
        repeat (4) @(negedge clk);
        chk(sel_idx == 1 && grant == '0, "R9 hold after done", sel_idx, 1);
        jog_wr = 1'b1;
        @(negedge clk);
        jog_wr = 1'b0;
        @(negedge clk);
        chk(grant == 8'b0000_0100, "R9 second step grant", grant, 4);
        bringup_done[2] = 1'b1;
        @(negedge clk);
        bringup_done[2] = 1'b0;
        repeat (2) @(negedge clk);
        jog_mode = 1'b0;
        wait_grant(k);
        chk(k == 8 && grant == 8'b0000_0010, "R11 resume from next position", k, 8);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule